// File: doc/BRIEF.md
# Halving XOR Phase-Frequency Detector

This block compares a reference pulse stream with a feedback (divided-oscillator) pulse stream and produces a one-bit bipolar error plus a windowed signed average of it. Both inputs are single-bit signals sampled on the system clock. Each input first drives its own toggle stage, which flips on every low-to-high transition of that input. The two half-rate signals are then compared by exclusive-OR, giving an error that is +1 when they differ and −1 when they agree. The averaged result therefore rises linearly across a full 2π of input phase difference, with a slope of 1/π per radian. That is twice the slope factor of a three-state detector.

A plain exclusive-OR comparison loses the sign of a frequency offset during cycle slipping. A steering stage fixes this. It watches the rising edges of the two half-rate signals. When one side produces two rising edges with no rising edge from the other side in between, the output is forced to the polarity that pulls the loop toward lock. The force stays on until the half-rate edges have alternated for a programmable number of consecutive events. An averager adds the ±1 error over a programmable window of clock cycles. At the close of each window it presents the sum with a one-cycle valid strobe, and the same cycle starts a new window from zero.

Top module: `xor_halving_pfd`

## Requirements
- R1: A synchronous reset clears both toggle stages, the steering state and the averager. During reset and on the first cycle after it, `errBit` is 0, `avgValid` is 0 and `avgOut` is 0.
- R2: A toggle stage changes state only in a clock cycle in which its input is 1 and was 0 in the previous cycle (or the previous cycle was in reset). A falling input changes nothing.
- R3: With no steering active, `errBit` is 1 (meaning +1) when the two half-rate signals differ and 0 (meaning −1) when they are equal. It updates on the same clock edge as the toggle stages.
- R4: When two half-rate reference rising edges occur with no half-rate feedback rising edge between them, `errBit` is forced to 1 from that edge on, regardless of the exclusive-OR result.
- R5: When two half-rate feedback rising edges occur with no half-rate reference rising edge between them, `errBit` is forced to 0 from that edge on.
- R6: A half-rate rising edge that follows a rising edge of the other half-rate signal counts as an alternation, and so does a coincident pair. A double edge resets the count. When the count reaches `ALT_REL` (default 4), the force is released and `errBit` follows R3 again on that same edge.
- R7: The window length is `winLen` clock cycles, and a value of 0 acts as 1. At the close of each window, `avgValid` is 1 for one cycle. `avgOut` then holds the sum of +1 for every cycle in which `errBit` was 1 and −1 for every cycle in which it was 0, over that window. The first close comes `winLen` clock edges after reset is released.
- R8: The cycle that closes a window adds its own sample to the closing sum, and the next window starts from zero. With a window of one cycle, `avgOut` is always exactly +1 or −1, matching the `errBit` of the previous cycle.
- R9: `avgOut` changes only in a cycle in which `avgValid` is 1.
- R10: Over long windows, a reference running faster than the feedback gives a positive `avgOut`, and a slower reference gives a negative one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 1 | Reference pulse stream, synchronous to clk |
| divIn | input | 1 | Feedback pulse stream, synchronous to clk |
| winLen | input | WIN_W | Averaging window length in clock cycles (0 acts as 1) |
| errBit | output | 1 | Bipolar error, 1 = +1, 0 = −1 |
| avgOut | output | WIN_W+1 | Signed sum of the error over the last completed window |
| avgValid | output | 1 | One-cycle strobe when avgOut is updated |

## Verification
The averager can close a window and take a fresh error sample in the same cycle. That sample must land in the closing sum and must not leak into the next window. The bench provokes this case by setting a one-cycle window, and separately a zero window, so that every cycle is both a close and a start. It then toggles the reference so that the error changes from cycle to cycle. Each published sum must be exactly ±1 and must equal the error seen one cycle earlier. A stale accumulator would show up as ±2 or as a wrong sign.

// File: rtl/pfdx_pkg.sv
package pfdx_pkg;

  typedef enum logic [1:0] {
    STEER_NONE = 2'd0,
    STEER_UP   = 2'd1,
    STEER_DN   = 2'd2
  } steer_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_REF  = 2'd1,
    EDGE_DIV  = 2'd2
  } edge_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rawDiff;
    logic forceHi;
    logic forceLo;
    logic closeWin;
  } strobe_t;

endpackage

// File: rtl/pfdx_ctrl.sv
module pfdx_ctrl
  import pfdx_pkg::*;
#(
  parameter int WIN_W   = 10,
  parameter int ALT_REL = 4,
  localparam int ALT_W  = (ALT_REL > 2) ? $clog2(ALT_REL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refIn,
  input  logic             divIn,
  input  logic [WIN_W-1:0] winLen,
  output strobe_t          stb
);

  logic refPrev, divPrev;
  logic refHalf, divHalf;
  steer_e steer;
  edge_e lastEdge;
  logic [ALT_W-1:0] altCnt;
  logic [WIN_W-1:0] winCnt;

  logic refRise, divRise, refHalfRise, divHalfRise;
  logic bothRise, refOnly, divOnly, altEv, dblRef, dblDiv;
  logic [WIN_W-1:0] winEff;

  always_comb begin
    refRise     = refIn & ~refPrev;
    divRise     = divIn & ~divPrev;
    refHalfRise = refRise & ~refHalf;
    divHalfRise = divRise & ~divHalf;
    bothRise    = refHalfRise & divHalfRise;
    refOnly     = refHalfRise & ~divHalfRise;
    divOnly     = divHalfRise & ~refHalfRise;
    dblRef      = refOnly & (lastEdge == EDGE_REF);
    dblDiv      = divOnly & (lastEdge == EDGE_DIV);
    altEv       = bothRise | (refOnly & (lastEdge == EDGE_DIV))
                           | (divOnly & (lastEdge == EDGE_REF));
    winEff      = (winLen == '0) ? WIN_W'(1) : winLen;
  end

  // input edge history and toggle stages
  always_ff @(posedge clk) begin
    if (rst) begin
      refPrev <= 1'b0;
      divPrev <= 1'b0;
      refHalf <= 1'b0;
      divHalf <= 1'b0;
    end else begin
      refPrev <= refIn;
      divPrev <= divIn;
      refHalf <= refHalf ^ refRise;
      divHalf <= divHalf ^ divRise;
    end
  end

  // frequency steering state
  always_ff @(posedge clk) begin
    if (rst) begin
      steer    <= STEER_NONE;
      lastEdge <= EDGE_NONE;
      altCnt   <= '0;
    end else begin
      if (dblRef) begin
        steer  <= STEER_UP;
        altCnt <= '0;
      end else if (dblDiv) begin
        steer  <= STEER_DN;
        altCnt <= '0;
      end else if (altEv) begin
        if (altCnt >= ALT_W'(ALT_REL - 1)) steer <= STEER_NONE;
        else altCnt <= altCnt + 1'b1;
      end
      if (bothRise)     lastEdge <= EDGE_NONE;
      else if (refOnly) lastEdge <= EDGE_REF;
      else if (divOnly) lastEdge <= EDGE_DIV;
    end
  end

  // averaging window counter
  always_ff @(posedge clk) begin
    if (rst) winCnt <= '0;
    else if (stb.closeWin) winCnt <= '0;
    else winCnt <= winCnt + 1'b1;
  end

  always_comb begin
    stb.rawDiff  = refHalf ^ divHalf;
    stb.forceHi  = (steer == STEER_UP);
    stb.forceLo  = (steer == STEER_DN);
    stb.closeWin = (winCnt >= winEff - WIN_W'(1));
  end

endmodule

// File: rtl/pfdx_dp.sv
module pfdx_dp
  import pfdx_pkg::*;
#(
  parameter int AVG_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 stb,
  output logic                    errBit,
  output logic signed [AVG_W-1:0] avgOut,
  output logic                    avgValid
);

  logic signed [AVG_W-1:0] acc, step, sum;

  always_comb begin
    errBit = stb.forceHi | (stb.rawDiff & ~stb.forceLo);
    step   = errBit ? AVG_W'(1) : {AVG_W{1'b1}};
    sum    = acc + step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      avgOut   <= '0;
      avgValid <= 1'b0;
    end else if (stb.closeWin) begin
      acc      <= '0;
      avgOut   <= sum;
      avgValid <= 1'b1;
    end else begin
      acc      <= sum;
      avgValid <= 1'b0;
    end
  end

endmodule

// File: rtl/xor_halving_pfd.sv
module xor_halving_pfd
  import pfdx_pkg::*;
#(
  parameter int WIN_W   = 10,
  parameter int ALT_REL = 4,
  localparam int AVG_W  = WIN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    refIn,
  input  logic                    divIn,
  input  logic [WIN_W-1:0]        winLen,
  output logic                    errBit,
  output logic signed [AVG_W-1:0] avgOut,
  output logic                    avgValid
);

  strobe_t stb;

  pfdx_ctrl #(.WIN_W(WIN_W), .ALT_REL(ALT_REL)) ctrl_i (
    .clk(clk), .rst(rst), .refIn(refIn), .divIn(divIn),
    .winLen(winLen), .stb(stb)
  );

  pfdx_dp #(.AVG_W(AVG_W)) dp_i (
    .clk(clk), .rst(rst), .stb(stb),
    .errBit(errBit), .avgOut(avgOut), .avgValid(avgValid)
  );

endmodule

// File: rtl/pfdx_chk.sv
module pfdx_chk #(
  parameter int WIN_W = 10,
  localparam int AVG_W = WIN_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [WIN_W-1:0]        winLen,
  input logic                    errBit,
  input logic signed [AVG_W-1:0] avgOut,
  input logic                    avgValid
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!errBit && !avgValid && avgOut == '0));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    (avgValid && winLen > WIN_W'(1)) |=> (!avgValid || winLen != $past(winLen)));

  assert_unit_window_R8: assert property (@(posedge clk) disable iff (rst)
    (avgValid && $past(avgValid) && winLen == WIN_W'(1) && $past(winLen) == WIN_W'(1))
      |-> (avgOut == ($past(errBit) ? AVG_W'(1) : {AVG_W{1'b1}})));

  assert_unit_magnitude_R8: assert property (@(posedge clk) disable iff (rst)
    (avgValid && $past(avgValid) && winLen == WIN_W'(1) && $past(winLen) == WIN_W'(1))
      |-> (avgOut == AVG_W'(1) || avgOut == {AVG_W{1'b1}}));

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
    !avgValid |-> $stable(avgOut));

endmodule

bind xor_halving_pfd pfdx_chk #(.WIN_W(WIN_W)) chk_i (
  .clk(clk), .rst(rst), .winLen(winLen),
  .errBit(errBit), .avgOut(avgOut), .avgValid(avgValid)
);

// File: tb/xor_halving_pfd_test.sv
`timescale 1ns/1ps
module xor_halving_pfd_test;

  localparam int WIN_W = 10;
  localparam int AVG_W = WIN_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refIn = 1'b0;
  logic divIn = 1'b0;
  logic [WIN_W-1:0] winLen = WIN_W'(4);
  logic errBit;
  logic signed [AVG_W-1:0] avgOut;
  logic avgValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xor_halving_pfd #(.WIN_W(WIN_W), .ALT_REL(4)) uut (
    .clk(clk), .rst(rst), .refIn(refIn), .divIn(divIn), .winLen(winLen),
    .errBit(errBit), .avgOut(avgOut), .avgValid(avgValid)
  );

  // {refIn, divIn, expected errBit, requirement code}
  localparam logic [5:0] VEC [33] = '{
    6'b00_0_000, 6'b10_1_001, 6'b00_1_001, 6'b10_0_001, 6'b01_1_000,
    6'b00_1_000, 6'b10_0_000, 6'b00_0_000, 6'b10_1_000, 6'b00_1_000,
    6'b10_1_010, 6'b01_1_010, 6'b00_1_010, 6'b01_1_010, 6'b10_1_010,
    6'b00_1_010, 6'b10_1_010, 6'b01_1_010, 6'b00_1_010, 6'b01_1_010,
    6'b10_1_010, 6'b00_1_010, 6'b10_0_011, 6'b00_0_011, 6'b01_1_011,
    6'b00_1_011, 6'b01_0_011, 6'b00_0_011, 6'b01_1_011, 6'b00_1_011,
    6'b01_0_100, 6'b10_0_100, 6'b00_0_100
  };

  function automatic string reqName(input logic [2:0] code);
    case (code)
      3'd0: return "R3";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic [WIN_W-1:0] w);
    @(negedge clk);
    rst = 1'b1; refIn = 1'b0; divIn = 1'b0; winLen = w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic freqRun(input int refPer, input int divPer, output int lastAvg);
    lastAvg = 0;
    for (int c = 0; c < 1200; c++) begin
      refIn = (c % refPer) < (refPer / 2);
      divIn = (c % divPer) < (divPer / 2);
      @(negedge clk);
      if (avgValid) lastAvg = int'(avgOut);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    int lastAvg;
    logic prevErr;

    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", errBit == 1'b0 && avgValid == 1'b0 && avgOut == 0, int'(errBit), 0);
    winLen = WIN_W'(0);
    @(negedge clk);
    rst = 1'b0;

    // vector table: R2, R3, R4, R5, R6
    for (int i = 0; i < 33; i++) begin
      refIn = VEC[i][5];
      divIn = VEC[i][4];
      @(negedge clk);
      check(reqName(VEC[i][2:0]), errBit == VEC[i][3], int'(errBit), int'(VEC[i][3]));
    end

    // R7: window of 4 with constant -1 error
    doReset(WIN_W'(4));
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!avgValid && cnt < 20);
    check("R7", cnt == 4, cnt, 4);
    check("R7", avgOut == -4, int'(avgOut), -4);
    @(negedge clk);
    check("R7", avgValid == 1'b0, int'(avgValid), 0);
    cnt = 1;
    do begin @(negedge clk); cnt++; end while (!avgValid && cnt < 20);
    check("R7", cnt == 4, cnt, 4);

    // R8: unit window, latch and clear in every cycle
    for (int pass = 0; pass < 2; pass++) begin
      doReset(pass == 0 ? WIN_W'(1) : WIN_W'(0));
      prevErr = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        check("R8", avgValid == 1'b1 && avgOut == (prevErr ? 1 : -1),
              int'(avgOut), prevErr ? 1 : -1);
        prevErr = errBit;
        refIn = k[0];
      end
    end

    // R9: hold between strobes, window 8
    doReset(WIN_W'(8));
    lastAvg = 0;
    for (int k = 0; k < 40; k++) begin
      refIn = k[1];
      @(negedge clk);
      if (avgValid) lastAvg = int'(avgOut);
      else check("R9", int'(avgOut) == lastAvg, int'(avgOut), lastAvg);
    end

    // R10: sign of the average follows the frequency offset
    doReset(WIN_W'(240));
    freqRun(6, 10, lastAvg);
    check("R10", lastAvg > 0, lastAvg, 1);
    doReset(WIN_W'(240));
    freqRun(10, 6, lastAvg);
    check("R10", lastAvg < 0, lastAvg, -1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule